// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Writer

This block drives a two-channel, 8-bit serial DAC as an SPI master. A client asks for an update of channel A, channel B or both, and supplies one 8-bit output code. The block builds a 16-bit word, sends it most significant bit first, and frames it with an active-low select line. The word is a device control byte followed by the straight-binary data byte, where 0x00 means zero volts and 0xFF means full reference.

The control byte is laid out as follows:

| Bit | Meaning |
| --- | --- |
| 7 | Reference select (0 = internal) |
| 6 | Unused, always 0 |
| 5 | Load and update both outputs |
| 4 | Power-down control for B |
| 3 | Power-down control for A |
| 2 | Channel select (0 = A) |
| 1:0 | Load mode |

The block always sends the internal reference and leaves the power-down bits at zero.

A dual update is sent as two frames, one after the other. The first frame loads A. The second loads B and updates both outputs. The serial clock idles high. Data changes only while the clock is low, so it is stable at every rising edge. Each clock half lasts DIV+1 system clocks, which gives a serial clock of the system clock divided by 2*(DIV+1).

Top module: `dac_cmd_writer`

## Requirements
- R1: Each frame holds exactly 16 rising SCLK edges. The bits are the control byte then the data byte, most significant bit first, and the data byte equals `req_data`.
- R2: `req_sel` = 2'b01 (channel A only) sends one frame with control byte 0x01.
- R3: `req_sel` = 2'b10 (channel B only) sends one frame with control byte 0x05.
- R4: `req_sel` = 2'b11 (both) sends two frames with the same data byte: first control 0x01, then control 0x24.
- R5: `req_sel` = 2'b00 is accepted and produces no frame. In the next cycle `sync_n` is still high and `req_ready` is high.
- R6: SCLK is high whenever `sync_n` is high. `sync_n` falls while SCLK is high, before the first falling SCLK edge.
- R7: Within a frame, `din` never changes while SCLK stays high.
- R8: Consecutive rising SCLK edges within a frame are 2*(DIV+1) system clocks apart.
- R9: `req_ready` is low whenever `sync_n` is low. An accepted non-empty request pulls `sync_n` low in the next cycle.
- R10: Between two frames of a dual update, `sync_n` stays high for at least 2*(DIV+1) system clocks.
- R11: After reset, `sync_n` and `sclk` are high and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_sel | input | 2 | Channel select: 01 = A, 10 = B, 11 = both, 00 = none |
| req_data | input | 8 | Straight-binary output code |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data to the DAC |
| sync_n | output | 1 | Active-low frame select |

## Verification
The bound checker examines several rules on every cycle:
- the clock is high whenever select is high;
- ready is low whenever select is low;
- data holds steady while the clock is high;
- an accepted request starts a frame;
- an empty request leaves the block idle.

Only the bench scenarios can show the rest, because each depends on a whole frame or a sequence of frames. The bench decodes each frame at its rising edges and compares the bits against the expected control and data bytes. It checks the ordering of the two frames in a dual update, the 16-bit count, the clock period between rising edges, and the high gap between frames.

// File: rtl/dac_cmd_writer.sv
module dac_cmd_writer #(
  parameter int unsigned DIV = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_sel,
  input  logic [7:0] req_data,
  output logic       sclk,
  output logic       din,
  output logic       sync_n
);
  localparam int unsigned CW = (DIV > 0) ? $clog2(DIV + 1) : 1;
  localparam logic [CW-1:0] DIV_C = CW'(DIV);
  localparam logic [7:0] CTL_A  = 8'h01;
  localparam logic [7:0] CTL_B  = 8'h05;
  localparam logic [7:0] CTL_AB = 8'h24;
  localparam logic [5:0] PH_LAST = 6'd32;
  localparam logic [5:0] PH_END  = 6'd34;

  logic          busy, pend;
  logic [5:0]    ph;
  logic [CW-1:0] dcnt;
  logic [15:0]   sr;
  logic [7:0]    val;

  wire tick     = (dcnt == DIV_C);
  wire accept   = req_valid && req_ready;
  wire in_frame = busy && (ph <= PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      ph   <= '0;
      dcnt <= '0;
      sr   <= '0;
      val  <= '0;
    end else if (accept) begin
      if (req_sel != 2'b00) begin
        busy <= 1'b1;
        pend <= (req_sel == 2'b11);
        ph   <= '0;
        dcnt <= '0;
        val  <= req_data;
        sr   <= {req_sel[0] ? CTL_A : CTL_B, req_data};
      end
    end else if (busy) begin
      if (tick) begin
        dcnt <= '0;
        if (ph == PH_END) begin
          if (pend) begin
            pend <= 1'b0;
            ph   <= '0;
            sr   <= {CTL_AB, val};
          end else begin
            busy <= 1'b0;
          end
        end else begin
          ph <= ph + 6'd1;
          if (!ph[0] && ph != 6'd0 && ph <= PH_LAST)
            sr <= {sr[14:0], 1'b0};
        end
      end else begin
        dcnt <= dcnt + CW'(1);
      end
    end
  end

  assign req_ready = !busy;
  assign sync_n    = !in_frame;
  assign sclk      = !(in_frame && ph != 6'd0 && ph[0]);
  assign din       = in_frame && sr[15];
endmodule

// File: rtl/dac_cmd_writer_chk.sv
module dac_cmd_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_sel,
  input logic [7:0] req_data,
  input logic       sclk,
  input logic       din,
  input logic       sync_n
);
  assert_idle_clock_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk);

  assert_ready_low_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> !req_ready);

  assert_accept_starts_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sel != 2'b00) |=> !sync_n);

  assert_empty_request_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sel == 2'b00) |=> (sync_n && req_ready));

  assert_data_stable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && sclk && $past(sclk) && !$past(sync_n)) |-> $stable(din));
endmodule

bind dac_cmd_writer dac_cmd_writer_chk chk_i (.*);

// File: tb/dac_cmd_writer_tb_top.sv
module dac_cmd_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int HALF = DIV + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_sel = 2'b00;
  logic [7:0] req_data = 8'h00;
  logic req_ready, sclk, din, sync_n;

  int n_chk = 0, n_err = 0, frames = 0, exp_frames = 0;
  bit done = 1'b0;
  logic [15:0] expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_writer #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_data(req_data), .sclk(sclk), .din(din), .sync_n(sync_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] sel, input logic [7:0] d);
    if (sel == 2'b01) begin expq.push_back({8'h01, d}); tagq.push_back("R2"); end
    if (sel == 2'b10) begin expq.push_back({8'h05, d}); tagq.push_back("R3"); end
    if (sel == 2'b11) begin
      expq.push_back({8'h01, d}); tagq.push_back("R4");
      expq.push_back({8'h24, d}); tagq.push_back("R4");
    end
    exp_frames += (sel == 2'b11) ? 2 : (sel == 2'b00 ? 0 : 1);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: decodes frames at rising SCLK edges and scores them
  logic p_sync = 1'b1, p_sclk = 1'b1, p_din = 1'b0;
  int bits = 0, since_rise = 0, gap = 0, fcount = 0;
  logic [15:0] word = '0;
  bit bad_per = 0, bad_din = 0, bad_rdy = 0, bad_idle = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_sync && !sync_n) begin
        // R6: select falls with the clock still high
        check(sclk == 1'b1, "R6 sclk at select fall", sclk, 1);
        // R10: gap between frames
        if (fcount > 0 && gap < 2*HALF + 1000 && exp_frames > fcount)
          if (gap < 1000) check(gap >= 2*HALF, "R10 select high gap", gap, 2*HALF);
        bits = 0; word = '0; since_rise = 0;
        bad_per = 0; bad_din = 0; bad_rdy = 0;
      end
      if (sync_n) begin
        gap++;
        if (!sclk) bad_idle = 1;
      end else begin
        gap = 0;
        since_rise++;
        if (req_ready) bad_rdy = 1;
        if (!p_sync && sclk && p_sclk && din != p_din) bad_din = 1;
        if (!p_sclk && sclk) begin
          if (bits > 0 && since_rise != 2*HALF) bad_per = 1;
          since_rise = 0;
          word = {word[14:0], din};
          bits++;
        end
      end
      if (!p_sync && sync_n) begin
        fcount++; frames++;
        check(bits == 16, "R1 rising edges per frame", bits, 16);
        check(!bad_per, "R8 sclk period", bad_per, 0);
        check(!bad_din, "R7 data stable while high", bad_din, 0);
        check(!bad_rdy, "R9 ready low in frame", bad_rdy, 0);
        if (expq.size() > 0) begin
          logic [15:0] e; string t;
          e = expq.pop_front(); t = tagq.pop_front();
          check(word == e, {t, " R1 frame word"}, word, e);
        end else check(1'b0, "R1 unexpected frame", word, 0);
      end
    end
    p_sync = sync_n; p_sclk = sclk; p_din = din;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(sync_n == 1'b1, "R11 sync_n in reset", sync_n, 1);
    check(sclk == 1'b1, "R11 sclk in reset", sclk, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);

    send(2'b01, 8'h00);
    send(2'b10, 8'hFF);
    send(2'b11, 8'hA5);
    // R5: empty request leaves the block idle
    send(2'b00, 8'h3C);
    check(sync_n == 1'b1 && req_ready == 1'b1, "R5 empty request", {sync_n, req_ready}, 3);
    repeat (40) @(negedge clk);
    check(sync_n == 1'b1, "R5 no frame started", sync_n, 1);
    send(2'b01, 8'h80);
    send(2'b11, 8'h01);
    send(2'b10, 8'h5A);
    send(2'b11, 8'hFE);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    check(frames == exp_frames, "R4 frame count", frames, exp_frames);
    check(expq.size() == 0, "R1 pending words", expq.size(), 0);
    check(!bad_idle, "R6 sclk high while idle", bad_idle, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog R9 actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule